// File: doc/BRIEF.md
# Accelerometer Self-Test Sequencer

This block runs a complete self-test on a three-axis accelerometer sample stream without help from software. After a start request it averages a programmable number of samples with the sensor's self-test stimulus off. It then raises a self-test enable output and throws away a programmable number of samples while the sensor output settles. Next it averages the same number of samples with the stimulus on, and finally drops the enable again.

For each axis the block reports the change in LSBs, which is the mean with the stimulus on minus the mean with it off. It compares the magnitude of each change against a per-axis minimum limit. The overall verdict is a single pass flag that is true only when all three axes reach their limits. A one-cycle done pulse marks the moment the results become valid.

A change that is much larger than expected still counts as a pass. The block has no upper limit check. The host sets the sample count and the settling length through a small configuration port, and writes that arrive while a test is running are ignored.

Top module: `selftest_seq`

## Requirements
- R1: After reset, st_en, done and pass are 0, all three differences are 0, the average count N is 10 and the settle count S is 4.
- R2: A start pulse while idle begins the baseline phase. During that phase st_en is 0, the next N cycles with smp_valid=1 are summed per axis, and cycles with smp_valid=0 contribute nothing.
- R3: st_en rises in the cycle right after the cycle in which the Nth baseline sample is accepted.
- R4: Once st_en is 1, the first S valid samples are discarded. With S=0 no sample is discarded. st_en stays 1 through the settling and measurement phases.
- R5: The measurement phase sums the next N valid samples. st_en falls in the cycle right after the Nth measurement sample is accepted.
- R6: diff_x, diff_y and diff_z are (sum_on − sum_off) / N, signed and truncated toward zero, SAMPLE_W+1 bits wide. They update in the same cycle as done and hold their value until the next completion.
- R7: An axis passes when the absolute value of its difference is greater than or equal to its unsigned limit, taken in the cycle in which st_en falls. pass is the AND of the three axis results, and no upper bound causes a failure.
- R8: done is a one-cycle pulse. It appears one cycle after st_en falls.
- R9: A start pulse that arrives while a sequence is running (from start acceptance until done) has no effect on the sequence or on its results.
- R10: cfg_we while idle loads N from cfg_n and S from cfg_settle. cfg_we while busy is ignored. A stored N of 0 behaves as N=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a self-test sequence |
| smp_valid | input | 1 | The sample inputs carry a new sample |
| smp_x | input | SAMPLE_W | X-axis sample, two's complement |
| smp_y | input | SAMPLE_W | Y-axis sample, two's complement |
| smp_z | input | SAMPLE_W | Z-axis sample, two's complement |
| cfg_we | input | 1 | Load the configuration values |
| cfg_n | input | CNT_W | Samples averaged per phase |
| cfg_settle | input | SETTLE_W | Samples discarded after the enable rises |
| lim_x | input | SAMPLE_W | X minimum change magnitude, unsigned |
| lim_y | input | SAMPLE_W | Y minimum change magnitude, unsigned |
| lim_z | input | SAMPLE_W | Z minimum change magnitude, unsigned |
| st_en | output | 1 | Self-test stimulus enable to the sensor |
| diff_x | output | SAMPLE_W+1 | X change in LSBs |
| diff_y | output | SAMPLE_W+1 | Y change in LSBs |
| diff_z | output | SAMPLE_W+1 | Z change in LSBs |
| pass | output | 1 | All axes reached their minimum |
| done | output | 1 | One-cycle completion pulse |

## Verification
If a phase counter is off by one, st_en moves a cycle early or late relative to the accepted samples, and the bench catches this at the very next sample boundary. Accumulation errors stay hidden until completion: a settling sample counted in error, a sum cleared by a start request during a run, or a skipped invalid cycle all corrupt the differences that are published with done. The settling samples are set to full scale so that any such leak moves the result by a large amount. Limits placed exactly at the magnitude, and one above it, check the comparison boundary in the pass output in the same cycle.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_BASE   = 3'd1,
    SQ_SETTLE = 3'd2,
    SQ_ACTIVE = 3'd3,
    SQ_FINISH = 3'd4
  } seq_state_t;

  localparam int unsigned NUM_AXES = 3;
endpackage

// File: rtl/selftest_ctrl.sv
module selftest_ctrl
  import selftest_pkg::*;
#(
  parameter int unsigned CNT_W      = 6,
  parameter int unsigned SETTLE_W   = 4,
  parameter int unsigned DEF_N      = 10,
  parameter int unsigned DEF_SETTLE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                smp_valid,
  input  logic                cfg_we,
  input  logic [CNT_W-1:0]    cfg_n,
  input  logic [SETTLE_W-1:0] cfg_settle,
  output logic                busy,
  output logic                st_en,
  output logic                acc_clr,
  output logic                acc_off_en,
  output logic                acc_on_en,
  output logic                latch_en,
  output logic [CNT_W-1:0]    n_eff
);
  seq_state_t          state;
  logic [CNT_W-1:0]    n_reg;
  logic [SETTLE_W-1:0] s_reg;
  logic [CNT_W-1:0]    cnt;
  logic [SETTLE_W-1:0] scnt;
  logic [CNT_W-1:0]    n_term;
  logic [SETTLE_W-1:0] s_term;
  logic                phase_last;
  logic                settle_last;

  assign n_eff       = (n_reg == '0) ? CNT_W'(1) : n_reg;
  assign n_term      = n_eff - CNT_W'(1);
  assign s_term      = s_reg - SETTLE_W'(1);
  assign phase_last  = (cnt == n_term);
  assign settle_last = (scnt == s_term);

  assign busy       = (state != SQ_IDLE);
  assign st_en      = (state == SQ_SETTLE) || (state == SQ_ACTIVE);
  assign acc_clr    = (state == SQ_IDLE) && start;
  assign acc_off_en = (state == SQ_BASE) && smp_valid;
  assign acc_on_en  = (state == SQ_ACTIVE) && smp_valid;
  assign latch_en   = (state == SQ_FINISH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_reg <= CNT_W'(DEF_N);
      s_reg <= SETTLE_W'(DEF_SETTLE);
    end else if (cfg_we && (state == SQ_IDLE)) begin
      n_reg <= cfg_n;
      s_reg <= cfg_settle;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cnt   <= '0;
      scnt  <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (start) begin
            state <= SQ_BASE;
            cnt   <= '0;
          end
        end
        SQ_BASE: begin
          if (smp_valid) begin
            if (phase_last) begin
              cnt   <= '0;
              scnt  <= '0;
              state <= (s_reg == '0) ? SQ_ACTIVE : SQ_SETTLE;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        SQ_SETTLE: begin
          if (smp_valid) begin
            if (settle_last) state <= SQ_ACTIVE;
            else             scnt  <= scnt + SETTLE_W'(1);
          end
        end
        SQ_ACTIVE: begin
          if (smp_valid) begin
            if (phase_last) begin
              cnt   <= '0;
              state <= SQ_FINISH;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        SQ_FINISH: state <= SQ_IDLE;
        default:   state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/selftest_axis.sv
module selftest_axis #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned CNT_W    = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_clr,
  input  logic                       acc_off_en,
  input  logic                       acc_on_en,
  input  logic                       latch_en,
  input  logic signed [SAMPLE_W-1:0] smp,
  input  logic [CNT_W-1:0]           n_eff,
  input  logic [SAMPLE_W-1:0]        lim,
  output logic signed [SAMPLE_W:0]   diff_o,
  output logic                       pass_o
);
  localparam int unsigned AW = SAMPLE_W + CNT_W;
  localparam int unsigned DW = SAMPLE_W + 1;

  logic signed [AW-1:0] sum_off;
  logic signed [AW-1:0] sum_on;
  logic signed [AW-1:0] smp_ext;
  logic signed [DW-1:0] delta;

  // Mean change: (on - off) / n, truncated toward zero.
  function automatic logic signed [DW-1:0] mean_delta(
    input logic signed [AW-1:0] s_on,
    input logic signed [AW-1:0] s_off,
    input logic [CNT_W-1:0]     n
  );
    logic signed [AW:0] num;
    logic signed [AW:0] den;
    logic signed [AW:0] q;
    num = {s_on[AW-1], s_on} - {s_off[AW-1], s_off};
    den = $signed({{(AW + 1 - CNT_W){1'b0}}, n});
    q   = num / den;
    return q[DW-1:0];
  endfunction

  // Magnitude reaches the minimum limit.
  function automatic logic reaches(
    input logic signed [DW-1:0] d,
    input logic [SAMPLE_W-1:0]  l
  );
    logic [DW-1:0] mag;
    mag = d[DW-1] ? (~d + DW'(1)) : d;
    return mag >= {1'b0, l};
  endfunction

  assign smp_ext = {{CNT_W{smp[SAMPLE_W-1]}}, smp};
  assign delta   = mean_delta(sum_on, sum_off, n_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_off <= '0;
      sum_on  <= '0;
    end else if (acc_clr) begin
      sum_off <= '0;
      sum_on  <= '0;
    end else begin
      if (acc_off_en) sum_off <= sum_off + smp_ext;
      if (acc_on_en)  sum_on  <= sum_on + smp_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff_o <= '0;
      pass_o <= 1'b0;
    end else if (latch_en) begin
      diff_o <= delta;
      pass_o <= reaches(delta, lim);
    end
  end
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
  import selftest_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 12,
  parameter int unsigned CNT_W      = 6,
  parameter int unsigned SETTLE_W   = 4,
  parameter int unsigned DEF_N      = 10,
  parameter int unsigned DEF_SETTLE = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_x,
  input  logic signed [SAMPLE_W-1:0] smp_y,
  input  logic signed [SAMPLE_W-1:0] smp_z,
  input  logic                       cfg_we,
  input  logic [CNT_W-1:0]           cfg_n,
  input  logic [SETTLE_W-1:0]        cfg_settle,
  input  logic [SAMPLE_W-1:0]        lim_x,
  input  logic [SAMPLE_W-1:0]        lim_y,
  input  logic [SAMPLE_W-1:0]        lim_z,
  output logic                       st_en,
  output logic signed [SAMPLE_W:0]   diff_x,
  output logic signed [SAMPLE_W:0]   diff_y,
  output logic signed [SAMPLE_W:0]   diff_z,
  output logic                       pass,
  output logic                       done
);
  logic             busy;
  logic             acc_clr;
  logic             acc_off_en;
  logic             acc_on_en;
  logic             latch_en;
  logic [CNT_W-1:0] n_eff;

  logic signed [SAMPLE_W-1:0] smp_a  [NUM_AXES];
  logic [SAMPLE_W-1:0]        lim_a  [NUM_AXES];
  logic signed [SAMPLE_W:0]   diff_a [NUM_AXES];
  logic [NUM_AXES-1:0]        pass_v;

  assign smp_a[0] = smp_x;
  assign smp_a[1] = smp_y;
  assign smp_a[2] = smp_z;
  assign lim_a[0] = lim_x;
  assign lim_a[1] = lim_y;
  assign lim_a[2] = lim_z;

  selftest_ctrl #(
    .CNT_W(CNT_W), .SETTLE_W(SETTLE_W),
    .DEF_N(DEF_N), .DEF_SETTLE(DEF_SETTLE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid),
    .cfg_we(cfg_we), .cfg_n(cfg_n), .cfg_settle(cfg_settle),
    .busy(busy), .st_en(st_en), .acc_clr(acc_clr),
    .acc_off_en(acc_off_en), .acc_on_en(acc_on_en),
    .latch_en(latch_en), .n_eff(n_eff)
  );

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    selftest_axis #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_axis (
      .clk(clk), .rst_n(rst_n), .acc_clr(acc_clr),
      .acc_off_en(acc_off_en), .acc_on_en(acc_on_en),
      .latch_en(latch_en), .smp(smp_a[a]), .n_eff(n_eff),
      .lim(lim_a[a]), .diff_o(diff_a[a]), .pass_o(pass_v[a])
    );
  end

  assign diff_x = diff_a[0];
  assign diff_y = diff_a[1];
  assign diff_z = diff_a[2];
  assign pass   = &pass_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= latch_en;
  end
endmodule

// File: rtl/selftest_seq_chk.sv
module selftest_seq_chk #(
  parameter int unsigned SAMPLE_W = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       st_en,
  input logic                       done,
  input logic                       pass,
  input logic signed [SAMPLE_W:0]   diff_x,
  input logic signed [SAMPLE_W:0]   diff_y,
  input logic signed [SAMPLE_W:0]   diff_z,
  input logic [SAMPLE_W-1:0]        lim_x,
  input logic [SAMPLE_W-1:0]        lim_y,
  input logic [SAMPLE_W-1:0]        lim_z,
  input logic                       busy,
  input logic                       acc_clr,
  input logic                       acc_off_en,
  input logic                       acc_on_en,
  input logic                       latch_en
);
  function automatic logic [SAMPLE_W:0] absv(input logic signed [SAMPLE_W:0] d);
    return d[SAMPLE_W] ? (SAMPLE_W+1)'(-d) : d;
  endfunction

  p_idle_en_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !st_en);

  p_en_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_en) |-> $past(acc_off_en));

  p_meas_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_on_en |-> st_en);

  p_en_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_en) |-> $past(acc_on_en));

  p_done_after_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(latch_en));

  p_pass_rule_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass == ((absv(diff_x) >= {1'b0, $past(lim_x)}) &&
                       (absv(diff_y) >= {1'b0, $past(lim_y)}) &&
                       (absv(diff_z) >= {1'b0, $past(lim_z)}))));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !acc_clr);

  p_no_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !latch_en) |=> busy);
endmodule

bind selftest_seq selftest_seq_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .st_en(st_en), .done(done),
  .pass(pass), .diff_x(diff_x), .diff_y(diff_y), .diff_z(diff_z),
  .lim_x(lim_x), .lim_y(lim_y), .lim_z(lim_z), .busy(busy),
  .acc_clr(acc_clr), .acc_off_en(acc_off_en), .acc_on_en(acc_on_en),
  .latch_en(latch_en)
);

// File: tb/tb_selftest_seq.sv
module tb_selftest_seq;
  localparam int SW = 12;
  localparam int CW = 6;
  localparam int SWD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, smp_valid = 1'b0, cfg_we = 1'b0;
  logic signed [SW-1:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic [CW-1:0]  cfg_n = '0;
  logic [SWD-1:0] cfg_settle = '0;
  logic [SW-1:0]  lim_x = '0, lim_y = '0, lim_z = '0;
  logic st_en, pass, done;
  logic signed [SW:0] diff_x, diff_y, diff_z;

  int vecs = 0;
  int miss = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  selftest_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z), .cfg_we(cfg_we),
    .cfg_n(cfg_n), .cfg_settle(cfg_settle), .lim_x(lim_x), .lim_y(lim_y),
    .lim_z(lim_z), .st_en(st_en), .diff_x(diff_x), .diff_y(diff_y),
    .diff_z(diff_z), .pass(pass), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint trunc_mean(input longint son, input longint soff, input int n);
    longint d, m;
    d = son - soff;
    m = (d < 0) ? -d : d;
    m = m / n;
    return (d < 0) ? -m : m;
  endfunction

  function automatic longint mag(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic write_cfg(input int n, input int s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_n = CW'(n); cfg_settle = SWD'(s);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Idle cycles with junk start/cfg traffic while busy (R9, R10)
  task automatic gaps();
    int g;
    g = $urandom % 3;
    for (int k = 0; k < g; k++) begin
      smp_valid = 1'b0;
      start = 1'($urandom);
      cfg_we = 1'($urandom);
      cfg_n = CW'($urandom);
      cfg_settle = SWD'($urandom);
      smp_x = SW'($urandom); smp_y = SW'($urandom); smp_z = SW'($urandom);
      @(negedge clk);
    end
    start = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic put_sample(inout longint s[3]);
    smp_valid = 1'b1;
    smp_x = SW'($urandom); smp_y = SW'($urandom); smp_z = SW'($urandom);
    s[0] += longint'(smp_x); s[1] += longint'(smp_y); s[2] += longint'(smp_z);
    @(negedge clk);
  endtask

  // mode 0: random limits, 1: limits equal to magnitudes, 2: y limit one above
  task automatic run_seq(input int n, input int s, input int mode);
    longint soff[3], son[3], ex[3];
    bit ep;
    soff = '{0, 0, 0}; son = '{0, 0, 0};
    @(negedge clk);
    start = 1'b1; smp_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(st_en == 1'b0, "R2 st_en low in baseline", st_en, 0);
    for (int i = 0; i < n; i++) begin
      gaps();
      put_sample(soff);
      if (i < n - 1) chk(st_en == 1'b0, "R2 st_en low in baseline", st_en, 0);
      else           chk(st_en == 1'b1, "R3 st_en rises after Nth sample", st_en, 1);
    end
    for (int i = 0; i < s; i++) begin
      gaps();
      smp_valid = 1'b1;
      smp_x = 12'sd2047; smp_y = -12'sd2048; smp_z = 12'sd2047;
      @(negedge clk);
      chk(st_en == 1'b1, "R4 st_en high while settling", st_en, 1);
    end
    for (int i = 0; i < n; i++) begin
      gaps();
      put_sample(son);
      if (i < n - 1) chk(st_en == 1'b1, "R4 st_en high in measurement", st_en, 1);
      else begin
        chk(st_en == 1'b0, "R5 st_en falls after Nth sample", st_en, 0);
        chk(done == 1'b0, "R8 done not yet", done, 0);
      end
    end
    smp_valid = 1'b0;
    for (int a = 0; a < 3; a++) ex[a] = trunc_mean(son[a], soff[a], n);
    if (mode == 0) begin
      lim_x = SW'($urandom % 200); lim_y = SW'($urandom % 200); lim_z = SW'($urandom % 200);
    end else begin
      lim_x = SW'(mag(ex[0])); lim_y = SW'(mag(ex[1])); lim_z = SW'(mag(ex[2]));
      if (mode == 2) lim_y = SW'(mag(ex[1]) + 1);
    end
    ep = (mag(ex[0]) >= longint'(lim_x)) && (mag(ex[1]) >= longint'(lim_y)) &&
         (mag(ex[2]) >= longint'(lim_z));
    @(negedge clk);
    chk(done == 1'b1, "R8 done pulse", done, 1);
    chk(longint'(diff_x) == ex[0], "R6 diff_x", diff_x, ex[0]);
    chk(longint'(diff_y) == ex[1], "R6 diff_y", diff_y, ex[1]);
    chk(longint'(diff_z) == ex[2], "R6 diff_z", diff_z, ex[2]);
    chk(pass == ep, "R7 pass", pass, ep);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
    chk(longint'(diff_x) == ex[0], "R6 diff held", diff_x, ex[0]);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miss++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(st_en == 1'b0, "R1 reset st_en", st_en, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(pass == 1'b0, "R1 reset pass", pass, 0);
    chk(diff_x == '0 && diff_y == '0 && diff_z == '0, "R1 reset diffs", diff_x, 0);
    run_seq(10, 4, 1);                  // R1 defaults N=10, S=4
    write_cfg(3, 0);  run_seq(3, 0, 2); // R4 no settling, R7 one below limit
    write_cfg(0, 2);  run_seq(1, 2, 1); // R10 N=0 acts as 1
    write_cfg(1, 1);  run_seq(1, 1, 0);
    write_cfg(63, 15); run_seq(63, 15, 1);
    for (int t = 0; t < 25; t++) begin
      int n, s;
      n = 1 + ($urandom % 12);
      s = $urandom % 8;
      write_cfg(n, s);
      run_seq(n, s, $urandom % 3);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule